// File: doc/BRIEF.md
# Serial Command Decoder with Quad Lanes

This block is the slave side of a serial flash-style command port. A host lowers the select line, clocks in an 8-bit command on one lane, and then either receives a response stream or sends a write payload. Depending on the command, the payload uses one lane or four. Read commands answer with one of three status bytes, or with a byte stream taken from an attached memory. Write commands update a writable status byte, load a 32-bit nonce and turn on a cipher-enable flag, or store one byte into memory.

The block runs entirely on a fast system clock and oversamples the serial clock and the select line. Both are assumed to be synchronous to that clock already. Each level of the serial clock must last at least three system clocks. The block samples input data on the serial clock's rising edge and changes its outputs after the falling edge. A write has an effect only if the select line is raised exactly when the last payload bit is in. A read may be cut off after any bit.

Top module: `sdec_top`

## Requirements
- R1: After `rst`, `dq_oe` is 0, `stat2_out` holds STAT2_INIT (0x00), `nonce_out` is 0 and `cipher_en` is 0.
- R2: While `ss_n` is high, the bit count and the phase return to the idle command phase, and `dq_oe` is 0 from the next system clock. A read cut off in the middle of a byte leaves the block ready for a fresh command.
- R3: The command byte is taken MSB first from `dq_in[0]` on rising serial-clock edges, and outputs change only after falling edges. Single-lane responses appear on `dq_out[1]` with `dq_oe` = 4'b0010.
- R4: Commands 0x05, 0x1F and 0x2F return `stat0_in`, `stat1_in` and `stat2_out` respectively, MSB first and starting on the clock after the command. The same byte repeats for as long as clocking continues.
- R5: Command 0x3F loads the next 8 single-lane bits into `stat2_out`. This happens only if `ss_n` rises after exactly 8 payload bits; with 7 or 9 bits the register is left unchanged.
- R6: Command 0x4F loads the next 32 single-lane bits, MSB first, into `nonce_out` and sets `cipher_en`. This happens only if `ss_n` rises after exactly 32 payload bits; with any other count both are left unchanged.
- R7: Command 0x0B takes a 24-bit address MSB first on one lane, followed by 8 dummy clocks. It then streams bytes from consecutive addresses on `dq_out[1]`. Each byte is fetched with a one-cycle `mem_rd` pulse, and `mem_rdata` is valid one system clock later.
- R8: Command 0xEB takes the address as 6 nibbles on `dq_in[3:0]` (`dq_in[3]` most significant, high nibble first), followed by 4 dummy clocks. It then streams bytes high nibble first on `dq_out[3:0]` with `dq_oe` = 4'hF.
- R9: Command 0x02 takes a 24-bit address and then one data byte on one lane. If `ss_n` rises after exactly 32 bits, it gives a single `mem_wr` pulse with that address and data; otherwise it gives none.
- R10: Command 0x38 takes the same 32 bits as 8 nibbles on four lanes, with the same exact-boundary rule for the `mem_wr` pulse.
- R11: An unrecognised command is ignored: `dq_oe` stays 0 until `ss_n` goes high, and no register or memory write occurs.
- R12: Once set, `cipher_en` stays set until `rst`; a later nonce load that is cut short does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, idle low |
| ss_n | input | 1 | Select, active low |
| dq_in | input | 4 | Serial data lanes from the host |
| dq_out | output | 4 | Serial data lanes to the host |
| dq_oe | output | 4 | Per-lane output enable |
| stat0_in | input | 8 | Read-only status byte 0 |
| stat1_in | input | 8 | Read-only status byte 1 |
| stat2_out | output | 8 | Writable status byte |
| nonce_out | output | NONCE_W | Nonce register |
| cipher_en | output | 1 | Cipher enable flag |
| mem_addr | output | ADDR_W | Memory address for read or write |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_rd` |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
On every cycle, the assertions check the following:
- Output enables are cleared and stay legal while deselected.
- Output lanes stay still between falling serial-clock edges.
- Unknown commands never drive the bus.
- At most one commit fires at a time.
- A memory write only follows a payload phase.
- The cipher flag never drops.

Only the bench's scenarios can show the exact-boundary commit rule at 7, 9, 31 and 33 bits, the lane ordering of addresses and data, the address increment across byte boundaries, and the repetition of status bytes.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  localparam logic [7:0] OP_RDST0 = 8'h05;
  localparam logic [7:0] OP_RDST1 = 8'h1F;
  localparam logic [7:0] OP_RDST2 = 8'h2F;
  localparam logic [7:0] OP_WRST2 = 8'h3F;
  localparam logic [7:0] OP_NONCE = 8'h4F;
  localparam logic [7:0] OP_RD1   = 8'h0B;
  localparam logic [7:0] OP_RD4   = 8'hEB;
  localparam logic [7:0] OP_WR1   = 8'h02;
  localparam logic [7:0] OP_WR4   = 8'h38;

  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUMMY, PH_DOUT, PH_WPAY, PH_SKIP} phase_t;
  typedef enum logic [1:0] {SRC_ST0, SRC_ST1, SRC_ST2, SRC_MEM} src_t;
  typedef enum logic [1:0] {WK_NONE, WK_ST2, WK_NONCE, WK_MEM} wkind_t;
endpackage

// File: rtl/sdec_edge.sv
module sdec_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic ss_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic ss_rise,
  output logic active
);
  logic sck_r, ssn_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_r <= 1'b0;
      ssn_r <= 1'b1;
    end else begin
      sck_r <= sck;
      ssn_r <= ss_n;
    end
  end

  assign active   = ~ss_n;
  assign sck_rise = sck & ~sck_r & ~ss_n;
  assign sck_fall = ~sck & sck_r & ~ss_n;
  assign ss_rise  = ss_n & ~ssn_r;
endmodule

// File: rtl/sdec_regs.sv
module sdec_regs #(
  parameter int         NONCE_W    = 32,
  parameter int         PAY_W      = 32,
  parameter logic [7:0] STAT2_INIT = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_st2,
  input  logic               wr_nonce,
  input  logic [PAY_W-1:0]   pay,
  output logic [7:0]         stat2,
  output logic [NONCE_W-1:0] nonce,
  output logic               cipher_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat2     <= STAT2_INIT;
      nonce     <= '0;
      cipher_en <= 1'b0;
    end else begin
      if (wr_st2) stat2 <= pay[7:0];
      if (wr_nonce) begin
        nonce     <= pay[NONCE_W-1:0];
        cipher_en <= 1'b1;
      end
    end
  end

  // R12
  cipher_sticky_chk: assert property (@(posedge clk) disable iff (rst) !$fell(cipher_en));

  // R6
  cipher_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cipher_en) |-> $past(wr_nonce));
endmodule

// File: rtl/sdec_core.sv
module sdec_core
  import sdec_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NONCE_W     = 32,
  parameter int FREAD_DUMMY = 8,
  parameter int QREAD_DUMMY = 4,
  parameter int PAY_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              ss_rise,
  input  logic              active,
  input  logic [3:0]        dq_in,
  input  logic [7:0]        st0,
  input  logic [7:0]        st1,
  input  logic [7:0]        st2,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        dq_out,
  output logic [3:0]        dq_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              wr_st2,
  output logic              wr_nonce,
  output logic [PAY_W-1:0]  pay
);
  localparam int CNT_W = $clog2(PAY_W + 8) + 1;
  localparam logic [CNT_W-1:0] NEED_ST2 = CNT_W'(8);
  localparam logic [CNT_W-1:0] NEED_NON = CNT_W'(NONCE_W);
  localparam logic [CNT_W-1:0] NEED_MEM = CNT_W'(ADDR_W + 8);
  localparam logic [CNT_W-1:0] NEED_ADR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] SAT_LIM  = CNT_W'(PAY_W);

  phase_t            phase;
  src_t              src;
  wkind_t            wkind;
  logic              quad, pf_pend;
  logic [7:0]        opc_sr, out_sr, pf_byte, byte_src;
  logic [3:0]        out_left;
  logic [CNT_W-1:0]  bits, step, dum_need;
  logic [ADDR_W-1:0] addr_sr, addr_next;
  logic [PAY_W-1:0]  pay_next;
  logic [7:0]        opc_full;

  assign step      = quad ? CNT_W'(4) : CNT_W'(1);
  assign dum_need  = quad ? CNT_W'(QREAD_DUMMY) : CNT_W'(FREAD_DUMMY);
  assign opc_full  = {opc_sr[6:0], dq_in[0]};
  assign addr_next = quad ? {addr_sr[ADDR_W-5:0], dq_in} : {addr_sr[ADDR_W-2:0], dq_in[0]};
  assign pay_next  = quad ? {pay[PAY_W-5:0], dq_in} : {pay[PAY_W-2:0], dq_in[0]};

  always_comb begin
    case (src)
      SRC_ST0: byte_src = st0;
      SRC_ST1: byte_src = st1;
      SRC_ST2: byte_src = st2;
      default: byte_src = pf_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    mem_rd   <= 1'b0;
    mem_wr   <= 1'b0;
    wr_st2   <= 1'b0;
    wr_nonce <= 1'b0;
    pf_pend  <= mem_rd;
    if (pf_pend) pf_byte <= mem_rdata;
    if (rst) begin
      phase <= PH_OPC; src <= SRC_ST0; wkind <= WK_NONE; quad <= 1'b0;
      bits <= '0; opc_sr <= '0; out_sr <= '0; out_left <= '0; pf_byte <= '0;
      pf_pend <= 1'b0; addr_sr <= '0; pay <= '0; dq_out <= '0; dq_oe <= '0;
      mem_addr <= '0; mem_wdata <= '0;
    end else if (!active) begin
      if (ss_rise && phase == PH_WPAY) begin
        case (wkind)
          WK_ST2:   if (bits == NEED_ST2) wr_st2 <= 1'b1;
          WK_NONCE: if (bits == NEED_NON) wr_nonce <= 1'b1;
          WK_MEM:   if (bits == NEED_MEM) begin
            mem_wr    <= 1'b1;
            mem_addr  <= pay[ADDR_W+7:8];
            mem_wdata <= pay[7:0];
          end
          default: ;
        endcase
      end
      phase <= PH_OPC; bits <= '0; quad <= 1'b0; out_left <= '0;
      dq_oe <= '0; dq_out <= '0; wkind <= WK_NONE;
    end else if (sck_rise) begin
      case (phase)
        PH_OPC: begin
          opc_sr <= opc_full;
          bits   <= bits + CNT_W'(1);
          if (bits == CNT_W'(7)) begin
            bits <= '0;
            case (opc_full)
              OP_RDST0: begin phase <= PH_DOUT; src <= SRC_ST0; end
              OP_RDST1: begin phase <= PH_DOUT; src <= SRC_ST1; end
              OP_RDST2: begin phase <= PH_DOUT; src <= SRC_ST2; end
              OP_WRST2: begin phase <= PH_WPAY; wkind <= WK_ST2; end
              OP_NONCE: begin phase <= PH_WPAY; wkind <= WK_NONCE; end
              OP_RD1:   begin phase <= PH_ADDR; src <= SRC_MEM; end
              OP_RD4:   begin phase <= PH_ADDR; src <= SRC_MEM; quad <= 1'b1; end
              OP_WR1:   begin phase <= PH_WPAY; wkind <= WK_MEM; end
              OP_WR4:   begin phase <= PH_WPAY; wkind <= WK_MEM; quad <= 1'b1; end
              default:  phase <= PH_SKIP;
            endcase
          end
        end
        PH_ADDR: begin
          addr_sr <= addr_next;
          if (bits + step == NEED_ADR) begin
            phase    <= PH_DUMMY;
            bits     <= '0;
            mem_addr <= addr_next;
            mem_rd   <= 1'b1;
          end else begin
            bits <= bits + step;
          end
        end
        PH_DUMMY: begin
          if (bits + CNT_W'(1) == dum_need) begin
            phase <= PH_DOUT;
            bits  <= '0;
          end else begin
            bits <= bits + CNT_W'(1);
          end
        end
        PH_WPAY: begin
          pay <= pay_next;
          if (bits <= SAT_LIM) bits <= bits + step;
        end
        default: ;
      endcase
    end else if (sck_fall && phase == PH_DOUT) begin
      dq_oe <= quad ? 4'hF : 4'b0010;
      if (out_left == 4'd0) begin
        dq_out   <= quad ? byte_src[7:4] : {2'b00, byte_src[7], 1'b0};
        out_sr   <= quad ? {byte_src[3:0], 4'h0} : {byte_src[6:0], 1'b0};
        out_left <= quad ? 4'd4 : 4'd7;
        if (src == SRC_MEM) begin
          mem_addr <= mem_addr + ADDR_W'(1);
          mem_rd   <= 1'b1;
        end
      end else begin
        dq_out   <= quad ? out_sr[7:4] : {2'b00, out_sr[7], 1'b0};
        out_sr   <= quad ? {out_sr[3:0], 4'h0} : {out_sr[6:0], 1'b0};
        out_left <= out_left - (quad ? 4'd4 : 4'd1);
      end
    end
  end

  // R2
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst) !active |=> dq_oe == 4'h0);

  // R3
  oe_legal_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe == 4'h0 || dq_oe == 4'b0010 || dq_oe == 4'hF);

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !sck_fall) |=> $stable(dq_out));

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    phase == PH_SKIP |-> dq_oe == 4'h0);

  // R5
  one_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, wr_st2, wr_nonce}));

  // R9
  wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> $past(phase) == PH_WPAY);
endmodule

// File: rtl/sdec_top.sv
module sdec_top #(
  parameter int         ADDR_W      = 24,
  parameter int         NONCE_W     = 32,
  parameter int         FREAD_DUMMY = 8,
  parameter int         QREAD_DUMMY = 4,
  parameter logic [7:0] STAT2_INIT  = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck,
  input  logic               ss_n,
  input  logic [3:0]         dq_in,
  output logic [3:0]         dq_out,
  output logic [3:0]         dq_oe,
  input  logic [7:0]         stat0_in,
  input  logic [7:0]         stat1_in,
  output logic [7:0]         stat2_out,
  output logic [NONCE_W-1:0] nonce_out,
  output logic               cipher_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  input  logic [7:0]         mem_rdata,
  output logic               mem_wr,
  output logic [7:0]         mem_wdata
);
  localparam int PAY_W = (NONCE_W > ADDR_W + 8) ? NONCE_W : ADDR_W + 8;

  logic sck_rise, sck_fall, ss_rise, active, wr_st2, wr_nonce;
  logic [PAY_W-1:0] pay;

  sdec_edge u_edge (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .ss_rise(ss_rise), .active(active)
  );

  sdec_core #(
    .ADDR_W(ADDR_W), .NONCE_W(NONCE_W), .FREAD_DUMMY(FREAD_DUMMY),
    .QREAD_DUMMY(QREAD_DUMMY), .PAY_W(PAY_W)
  ) u_core (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .ss_rise(ss_rise), .active(active), .dq_in(dq_in),
    .st0(stat0_in), .st1(stat1_in), .st2(stat2_out), .mem_rdata(mem_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .wr_st2(wr_st2),
    .wr_nonce(wr_nonce), .pay(pay)
  );

  sdec_regs #(.NONCE_W(NONCE_W), .PAY_W(PAY_W), .STAT2_INIT(STAT2_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr_st2(wr_st2), .wr_nonce(wr_nonce), .pay(pay),
    .stat2(stat2_out), .nonce(nonce_out), .cipher_en(cipher_en)
  );
endmodule

// File: tb/tb_sdec_top.sv
module tb_sdec_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic ss_n = 1'b1;
  logic [3:0] dq_in = 4'h0;
  logic [3:0] dq_out, dq_oe;
  logic [7:0] stat0_in = 8'hA5;
  logic [7:0] stat1_in = 8'h3C;
  logic [7:0] stat2_out, mem_rdata, mem_wdata;
  logic [31:0] nonce_out;
  logic cipher_en, mem_rd, mem_wr;
  logic [23:0] mem_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int wr_seen = 0;

  typedef struct { string req; logic [31:0] v; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  sdec_top dut (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .stat0_in(stat0_in), .stat1_in(stat1_in),
    .stat2_out(stat2_out), .nonce_out(nonce_out), .cipher_en(cipher_en),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  function automatic logic [7:0] mval(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mval(mem_addr[7:0]);

  task automatic push(input string req, input logic [31:0] v);
    item_t it;
    it.req = req; it.v = v;
    exp_q.push_back(it);
  endtask

  task automatic got(input logic [31:0] v);
    item_t it;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected result: actual %h expected none", v);
    end else begin
      it = exp_q.pop_front();
      if (v !== it.v) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, v, it.v);
      end
    end
  endtask

  // monitor for memory writes (R9, R10)
  always @(negedge clk) begin
    if (!rst && mem_wr) begin
      wr_seen++;
      got({mem_addr, mem_wdata});
    end
  end

  task automatic tick(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    dq_in = d;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
    q = dq_out; oe = dq_oe;
    repeat (2) @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic sel;
    @(negedge clk); ss_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel;
    @(negedge clk); ss_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send1(input logic [63:0] v, input int n);
    logic [3:0] q, o;
    for (int i = n - 1; i >= 0; i--) tick({3'b000, v[i]}, q, o);
  endtask

  task automatic send4(input logic [31:0] v, input int n);
    logic [3:0] q, o;
    for (int i = n - 1; i >= 0; i--) tick(v[4*i +: 4], q, o);
  endtask

  task automatic rd_byte(input bit qd, output logic [7:0] b, output logic [3:0] oe);
    logic [3:0] q;
    b = '0;
    if (qd) begin
      tick(4'h0, q, oe); b[7:4] = q;
      tick(4'h0, q, oe); b[3:0] = q;
    end else begin
      for (int i = 7; i >= 0; i--) begin
        tick(4'h0, q, oe); b[i] = q[1];
      end
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic [3:0] oe, q, oe_or;
    int w0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    push("R1", 32'h0); got({28'h0, dq_oe});
    push("R1", 32'h0); got({24'h0, stat2_out});
    push("R1", 32'h0); got(nonce_out);
    push("R1", 32'h0); got({31'h0, cipher_en});

    // R4 status 0 repeats, R3 single-lane enable
    sel(); send1(64'h05, 8);
    rd_byte(1'b0, b, oe); push("R4", 32'hA5); got({24'h0, b});
    push("R3", 32'h2); got({28'h0, oe});
    rd_byte(1'b0, b, oe); push("R4", 32'hA5); got({24'h0, b});
    desel();
    push("R2", 32'h0); got({28'h0, dq_oe});

    sel(); send1(64'h1F, 8);
    rd_byte(1'b0, b, oe); push("R4", 32'h3C); got({24'h0, b});
    desel();

    // R5 write status 2: exact, then 9 and 7 bits
    sel(); send1(64'h3F, 8); send1(64'h96, 8); desel();
    push("R5", 32'h96); got({24'h0, stat2_out});
    sel(); send1(64'h3F, 8); send1(64'h1FF, 9); desel();
    sel(); send1(64'h3F, 8); send1(64'h11, 7); desel();
    sel(); send1(64'h2F, 8);
    rd_byte(1'b0, b, oe); push("R5", 32'h96); got({24'h0, b});
    rd_byte(1'b0, b, oe); push("R4", 32'h96); got({24'h0, b});
    desel();

    // R6 nonce: 33 bits rejected, 32 bits accepted
    sel(); send1(64'h4F, 8); send1(64'h1_CAFE_F00D, 33); desel();
    push("R6", 32'h0); got(nonce_out);
    push("R6", 32'h0); got({31'h0, cipher_en});
    sel(); send1(64'h4F, 8); send1(64'hDEAD_BEEF, 32); desel();
    push("R6", 32'hDEAD_BEEF); got(nonce_out);
    push("R6", 32'h1); got({31'h0, cipher_en});
    // R12 short nonce load keeps flag and value
    sel(); send1(64'h4F, 8); send1(64'h1234_567, 31); desel();
    push("R12", 32'h1); got({31'h0, cipher_en});
    push("R12", 32'hDEAD_BEEF); got(nonce_out);

    // R7 single-lane read from 0x000010
    sel(); send1(64'h0B, 8); send1(64'h000010, 24); send1(64'h0, 8);
    for (int k = 0; k < 3; k++) begin
      rd_byte(1'b0, b, oe); push("R7", {24'h0, mval(8'h10 + 8'(k))}); got({24'h0, b});
    end
    desel();

    // R8 quad read crossing 0xFF
    sel(); send1(64'hEB, 8); send4(32'h0000FE, 6); send4(32'h0, 4);
    for (int k = 0; k < 3; k++) begin
      rd_byte(1'b1, b, oe); push("R8", {24'h0, mval(8'hFE + 8'(k))}); got({24'h0, b});
    end
    push("R8", 32'hF); got({28'h0, oe});
    desel();

    // R2 read cut off mid-byte, then fresh command
    sel(); send1(64'h0B, 8); send1(64'h000020, 24); send1(64'h0, 8);
    for (int k = 0; k < 3; k++) tick(4'h0, q, oe);
    desel();
    push("R2", 32'h0); got({28'h0, dq_oe});
    sel(); send1(64'h1F, 8);
    rd_byte(1'b0, b, oe); push("R2", 32'h3C); got({24'h0, b});
    desel();

    // R9 page program exact and short
    push("R9", 32'h1234_5677);
    sel(); send1(64'h02, 8); send1(64'h1234_5677, 32); desel();
    w0 = wr_seen;
    sel(); send1(64'h02, 8); send1(64'h0055_6677, 31); desel();
    push("R9", 32'(w0)); got(32'(wr_seen));

    // R10 quad page program
    push("R10", 32'hABCD_EF3C);
    sel(); send1(64'h38, 8); send4(32'hABCD_EF3C, 8); desel();
    w0 = wr_seen;
    sel(); send1(64'h38, 8); send4(32'h0102_0304, 7); desel();
    push("R10", 32'(w0)); got(32'(wr_seen));

    // R11 unknown command stays quiet
    sel(); send1(64'h9F, 8);
    oe_or = 4'h0;
    for (int k = 0; k < 16; k++) begin
      tick(4'hF, q, oe); oe_or = oe_or | oe;
    end
    desel();
    push("R11", 32'h0); got({28'h0, oe_or});
    push("R11", 32'h96); got({24'h0, stat2_out});
    push("R11", 32'hDEAD_BEEF); got(nonce_out);

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: actual %0d pending writes expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule